// File: doc/BRIEF.md
# Prebias Startup Sequencer with Sink-Limit Ramp

This block sits in the digital control path of a synchronous step-down converter. It decides when the power stage may start switching, asks for the first period to begin with the low-side switch on (so that the bootstrap capacitor is charged before the high side fires), and steps the low-side sink-current limit code up from its lowest setting to its full setting over the first switching periods.

Two start modes exist. In plain forced-PWM mode, switching begins as soon as the block is enabled. In monotonic-start mode, meant for an output that may already carry a voltage, both switches stay off until the feedback voltage has crossed the soft-start ramp. This keeps the converter from discharging the output. Once the output has stayed at the power-good level for a set number of switching periods, a monotonic start hands over to plain forced-PWM behaviour. The mode is captured on the rising edge of enable. All timing is counted in switching periods, which `cyc_tick` marks one clock wide.

Top module: `prebias_sink_stepper`

## Requirements
- R1: While `rst_n` is low, `sw_en`, `ls_first` and `prebias_mode` are 0 and `sink_code` is 0.
- R2: If `mode_prebias` is 0 when `en` is first sampled high, `sw_en` is 1 from the next clock on.
- R3: If `mode_prebias` is 1 when `en` is first sampled high, `sw_en` stays 0 until `fb_above_ss` is sampled high while enabled. `sw_en` then rises on the next clock.
- R4: `ls_first` rises together with `sw_en`. It falls on the clock after the first `cyc_tick` sampled while switching, and it is never 1 while `sw_en` is 0.
- R5: `sink_code` is 0 when switching starts. It rises by one after every 32 ticks sampled while switching (0, 1, 2, 3) and holds at 3. It is 0 whenever `sw_en` is 0.
- R6: In monotonic-start mode while switching, `prebias_mode` (1 = monotonic start) falls on the clock after the 4096th consecutive tick sampled with `fb_pgood` high. Any clock that samples `fb_pgood` low restarts this count.
- R7: `mode_prebias` is captured only on the rising edge of `en`. Changes to it while `en` stays high have no effect on `sw_en` or `prebias_mode`.
- R8: A clock that samples `en` low returns every output to 0 on that edge. The next rising edge of `en` starts the sequence again from the beginning.
- R9: Once `sw_en` is 1, it stays 1 while `en` stays high, whatever `fb_above_ss` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| mode_prebias | input | 1 | Decoded start mode: 1 = monotonic start, 0 = plain forced PWM |
| fb_above_ss | input | 1 | Feedback has crossed the soft-start voltage |
| fb_pgood | input | 1 | Feedback is above the power-good fraction of the reference |
| cyc_tick | input | 1 | One-clock strobe marking the start of each switching period |
| sw_en | output | 1 | Power stage may switch |
| ls_first | output | 1 | First period must begin with the low-side switch |
| sink_code | output | 2 | Low-side sink-current limit step, 0 lowest to 3 full |
| prebias_mode | output | 1 | Block is in monotonic-start mode |

## Verification
The bench targets four kinds of timing error:
- Counting the tick on the clock where switching starts. A design that does this would end the low-side-first request and each sink-limit step one period early.
- Failing to restart the handover count when power-good drops. Such a design would leave monotonic-start mode after fewer than 4096 clean ticks.
- Reading the mode input continuously instead of capturing it on enable. A design that does this would change behaviour when the mode pin toggles mid-run.
- Letting `fb_above_ss` gate switching after start-up. Such a design would chop the output off when the feedback dips below the soft-start voltage.

Directed runs hit the exact 4095/4096 handover boundary. Long random runs with sparse ticks and enable cycling cover the remaining orderings.

// File: rtl/prebias_sink_stepper.sv
module prebias_sink_stepper #(
  parameter int STEP_TICKS     = 32,
  parameter int STEPS          = 4,
  parameter int HANDOVER_TICKS = 4096,
  localparam int CODE_W = $clog2(STEPS),
  localparam int STEP_W = $clog2(STEP_TICKS),
  localparam int RAMP_W = CODE_W + STEP_W,
  localparam int HO_W   = $clog2(HANDOVER_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode_prebias,
  input  logic              fb_above_ss,
  input  logic              fb_pgood,
  input  logic              cyc_tick,
  output logic              sw_en,
  output logic              ls_first,
  output logic [CODE_W-1:0] sink_code,
  output logic              prebias_mode
);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(STEPS - 1);
  localparam logic [HO_W-1:0]   HO_LAST  = HO_W'(HANDOVER_TICKS - 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_RUN} st_t;

  st_t              st;
  logic             en_q, mode_q, first_q;
  logic [RAMP_W-1:0] ramp;
  logic [HO_W-1:0]  ho_cnt;

  assign sw_en        = (st == S_RUN);
  assign ls_first     = first_q;
  assign sink_code    = ramp[RAMP_W-1:STEP_W];
  assign prebias_mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF; en_q <= 1'b0; mode_q <= 1'b0; first_q <= 1'b0;
      ramp <= '0; ho_cnt <= '0;
    end else begin
      en_q <= en;
      if (!en) begin
        st <= S_OFF; mode_q <= 1'b0; first_q <= 1'b0; ramp <= '0; ho_cnt <= '0;
      end else if (!en_q) begin
        mode_q  <= mode_prebias;
        st      <= mode_prebias ? S_WAIT : S_RUN;
        first_q <= !mode_prebias;
        ramp    <= '0;
        ho_cnt  <= '0;
      end else begin
        case (st)
          S_WAIT: if (fb_above_ss) begin
            st <= S_RUN;
            first_q <= 1'b1;
          end
          S_RUN: begin
            if (cyc_tick) begin
              first_q <= 1'b0;
              if (sink_code != CODE_TOP) ramp <= ramp + 1'b1;
            end
            if (mode_q) begin
              if (!fb_pgood) ho_cnt <= '0;
              else if (cyc_tick) begin
                if (ho_cnt == HO_LAST) begin
                  mode_q <= 1'b0;
                  ho_cnt <= '0;
                end else ho_cnt <= ho_cnt + 1'b1;
              end
            end
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/prebias_sink_stepper_chk.sv
module prebias_sink_stepper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       sw_en,
  input logic       ls_first,
  input logic [1:0] sink_code,
  input logic       prebias_mode
);
  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sw_en && !ls_first && sink_code == 2'd0 && !prebias_mode));

  p_code_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sink_code == $past(sink_code) || sink_code == $past(sink_code) + 2'd1 || sink_code == 2'd0));

  p_code_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> sink_code == 2'd0);

  p_first_needs_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ls_first |-> sw_en);

  p_keep_switching_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_en) |=> sw_en);

  p_no_mode_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_en && !prebias_mode) |=> !prebias_mode);
endmodule

bind prebias_sink_stepper prebias_sink_stepper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sw_en(sw_en), .ls_first(ls_first),
  .sink_code(sink_code), .prebias_mode(prebias_mode)
);

// File: tb/prebias_sink_stepper_tb.sv
module prebias_sink_stepper_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, mode_prebias = 0, fb_above_ss = 0, fb_pgood = 0, cyc_tick = 0;
  logic sw_en, ls_first, prebias_mode;
  logic [1:0] sink_code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prebias_sink_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_prebias(mode_prebias),
    .fb_above_ss(fb_above_ss), .fb_pgood(fb_pgood), .cyc_tick(cyc_tick),
    .sw_en(sw_en), .ls_first(ls_first), .sink_code(sink_code), .prebias_mode(prebias_mode)
  );

  // reference model of the requirements, stepped on each rising edge
  int m_st = 0, m_ramp = 0, m_hc = 0;
  bit m_mode = 0, m_first = 0, m_enq = 0;

  function automatic int code_of(int r);
    return r / 32;
  endfunction

  always @(posedge clk) begin
    bit pe;
    if (!rst_n) begin
      m_st = 0; m_ramp = 0; m_hc = 0; m_mode = 0; m_first = 0; m_enq = 0;
    end else begin
      pe = m_enq; m_enq = en;
      if (!en) begin
        m_st = 0; m_ramp = 0; m_hc = 0; m_mode = 0; m_first = 0;
      end else if (!pe) begin
        m_mode = mode_prebias; m_st = mode_prebias ? 1 : 2;
        m_first = !mode_prebias; m_ramp = 0; m_hc = 0;
      end else if (m_st == 1) begin
        if (fb_above_ss) begin m_st = 2; m_first = 1; end
      end else if (m_st == 2) begin
        if (cyc_tick) begin
          m_first = 0;
          if (m_ramp < 96) m_ramp++;
        end
        if (m_mode) begin
          if (!fb_pgood) m_hc = 0;
          else if (cyc_tick) begin
            m_hc++;
            if (m_hc == 4096) begin m_mode = 0; m_hc = 0; end
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 R3 R9 sw_en", sw_en, m_st == 2);
    chk("R4 ls_first", ls_first, m_first);
    chk("R5 sink_code", sink_code, code_of(m_ramp));
    chk("R6 R7 prebias_mode", prebias_mode, m_mode);
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    en = 1; mode_prebias = 1;
    step(3);
    chk("R1 reset sw_en", sw_en, 0);
    chk("R1 reset code", sink_code, 0);
    chk("R1 reset mode", prebias_mode, 0);
    en = 0; rst_n = 1;
    step(2);
    // forced start
    mode_prebias = 0; en = 1; cyc_tick = 0;
    step(1);
    chk("R2 forced start", sw_en, 1);
    chk("R4 first request", ls_first, 1);
    cyc_tick = 1; step(1);
    chk("R4 first cleared", ls_first, 0);
    step(31);
    chk("R5 step one", sink_code, 1);
    mode_prebias = 1; step(80);
    chk("R5 hold top", sink_code, 3);
    chk("R7 mode ignored", prebias_mode, 0);
    en = 0; step(1);
    chk("R8 off", sw_en, 0);
    // monotonic start with handover boundary
    en = 1; mode_prebias = 1; fb_above_ss = 0; fb_pgood = 0; step(20);
    chk("R3 held off", sw_en, 0);
    fb_above_ss = 1; step(1);
    chk("R3 started", sw_en, 1);
    fb_above_ss = 0; fb_pgood = 1; mode_prebias = 0;
    step(4000);
    fb_pgood = 0; step(1);
    fb_pgood = 1; step(4095);
    chk("R6 count restarted", prebias_mode, 1);
    chk("R9 still switching", sw_en, 1);
    step(1);
    chk("R6 handover", prebias_mode, 0);
    // random phase
    for (int i = 0; i < 60000; i++) begin
      if ($urandom_range(299) == 0) en = ~en;
      mode_prebias = $urandom_range(1);
      if ($urandom_range(19) == 0) fb_above_ss = ~fb_above_ss;
      fb_pgood = ($urandom_range(999) != 0);
      cyc_tick = ($urandom_range(3) != 0);
      step(1);
    end
    finish_run();
  end
endmodule